// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

This block sits in front of a word-interleaved scratchpad split into a power-of-two number of banks. It accepts one group of lane requests at a time: every lane brings an active flag, a word address and, for stores, a data word. The block decides which lanes each bank can serve in the current cycle. Lanes it cannot serve yet are retried in the cycles that follow, until every active lane has been served exactly once.

The bank of a lane is the low bits of its word address. The remaining upper bits select the row inside that bank. The address pattern across lanes is free: no alignment, stride or contiguity is assumed. In each cycle a bank follows the lowest-numbered pending lane that maps onto it. Every other pending lane on that bank that asks for the same word is served in the same cycle by broadcast. A request therefore needs as many cycles as the largest count of distinct words asked of any single bank. For stores, when several lanes name the same word, the data of the highest-numbered of them is the data written.

Control is a two-state machine. ST_IDLE waits for work. ST_SERVE drives one replay step per cycle. The transitions are:
- ACCEPT: ST_IDLE to ST_SERVE, taken when `req_valid` is high and at least one lane is active.
- STEP: ST_SERVE to ST_SERVE, taken while lanes remain pending after the current grants.
- FINISH: ST_SERVE to ST_IDLE, taken in the cycle that grants the last pending lanes.
- WAIT: ST_IDLE to ST_IDLE, taken otherwise.

Top module: `bank_conflict_resolver`

## Requirements
- R1: After reset, `busy`, `lane_grant`, `bank_en` and `bank_we` are all zero.
- R2: A lane's bank is bits [4:0] of its word address (with 32 banks). Its row is the bits above those. `lane_bank` reports the bank of each lane. In a cycle where a lane is granted, `bank_en` of its bank is high and that bank's `bank_addr` equals the lane's row.
- R3: When all active lanes fall on different banks, whatever their alignment or spacing, the request finishes in one cycle with every active lane granted.
- R4: In each cycle, each bank serves the word of its lowest-numbered pending lane. Distinct words of one bank are therefore served in order of the lowest lane that asks for each of them.
- R5: All pending lanes of a bank that ask for the word being served in that cycle are granted in the same cycle.
- R6: The number of cycles with `busy` high equals the maximum, over all banks, of the number of distinct words requested in that bank. Every cycle with `busy` high grants at least one lane.
- R7: Inactive lanes are never granted and never cost a cycle. A request with no active lane is not accepted, and `busy` stays low.
- R8: `busy` rises in the cycle after acceptance and falls after the cycle that grants the last pending lane. Each active lane is granted exactly once. While `busy` is low there are no grants and no bank enables.
- R9: A `req_valid` that arrives while `busy` is high is ignored: the grant sequence of the running request is unchanged, and no further request follows it.
- R10: On a store request, `bank_we` is high exactly for the enabled banks. `bank_wdata` carries the data of the highest-numbered lane granted on that bank in that cycle.
- R11: On a load request, `bank_we` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Offers a new lane request while idle |
| req_write | input | 1 | 1 = store request, 0 = load request |
| lane_active | input | LANES | Per-lane active flag |
| lane_addr | input | LANES*AW | Per-lane word address, lane l at bits [l*AW +: AW] |
| lane_wdata | input | LANES*DW | Per-lane store data, lane l at bits [l*DW +: DW] |
| busy | output | 1 | High while the request is being served |
| lane_grant | output | LANES | Lanes served in this cycle |
| lane_bank | output | LANES*BW | Bank select of each lane |
| bank_en | output | BANKS | Bank performs an access this cycle |
| bank_we | output | BANKS | Bank access is a write |
| bank_addr | output | BANKS*RW | Row accessed in each bank |
| bank_wdata | output | BANKS*DW | Write data for each bank |

## Verification
The bench builds the block with its defaults: 32 lanes, 32 banks, 12-bit word addresses and 32-bit data, so each bank has a 7-bit row. With these values the full range of replay depth can be reached. Unit stride, odd stride and unaligned bases all finish in a single cycle. The worst pattern, every lane on one bank with distinct rows, needs 32 cycles. Patterns in between cover broadcast groups, partial lane masks and store merging, with several writers on one word.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } bcr_state_e;

endpackage

// File: rtl/bcr_lane_map.sv
// Splits each lane's word address into bank select (low bits) and row (high bits).
module bcr_lane_map #(
    parameter int LANES = 32,
    parameter int AW    = 12,
    parameter int BW    = 5
) (
    input  logic [LANES*AW-1:0]      addr_flat,
    output logic [LANES*BW-1:0]      bank_flat,
    output logic [LANES*(AW-BW)-1:0] row_flat
);
    localparam int RW = AW - BW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bank_flat[l*BW +: BW] = addr_flat[l*AW +: BW];
        assign row_flat[l*RW +: RW]  = addr_flat[l*AW + BW +: RW];
    end
endmodule

// File: rtl/bcr_bank_arb.sv
// One bank: follow the lowest pending lane, grant every pending lane on the
// same word, and pick the highest granted lane's store data.
module bcr_bank_arb #(
    parameter int LANES   = 32,
    parameter int BW      = 5,
    parameter int RW      = 7,
    parameter int DW      = 32,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*BW-1:0] bank_flat,
    input  logic [LANES*RW-1:0] row_flat,
    input  logic [LANES*DW-1:0] wdata_flat,
    output logic                en,
    output logic [RW-1:0]       row,
    output logic [LANES-1:0]    grant,
    output logic [DW-1:0]       wdata
);
    localparam logic [BW-1:0] MY_BANK = BANK_ID[BW-1:0];

    logic [LANES-1:0] hit;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            hit[l] = pend[l] && (bank_flat[l*BW +: BW] == MY_BANK);
        end
    end

    // leader search: lowest-numbered hit lane
    always_comb begin
        en  = 1'b0;
        row = '0;
        for (int l = 0; l < LANES; l++) begin
            if (hit[l] && !en) begin
                en  = 1'b1;
                row = row_flat[l*RW +: RW];
            end
        end
    end

    // broadcast group and store merge (later lanes overwrite earlier ones)
    always_comb begin
        wdata = '0;
        for (int l = 0; l < LANES; l++) begin
            grant[l] = hit[l] && (row_flat[l*RW +: RW] == row);
            if (grant[l]) begin
                wdata = wdata_flat[l*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/bank_conflict_resolver.sv
module bank_conflict_resolver #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int AW    = 12,
    parameter int DW    = 32,
    parameter int BW    = $clog2(BANKS),
    parameter int RW    = AW - BW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [LANES-1:0]    lane_active,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                busy,
    output logic [LANES-1:0]    lane_grant,
    output logic [LANES*BW-1:0] lane_bank,
    output logic [BANKS-1:0]    bank_en,
    output logic [BANKS-1:0]    bank_we,
    output logic [BANKS*RW-1:0] bank_addr,
    output logic [BANKS*DW-1:0] bank_wdata
);
    import bcr_pkg::*;

    bcr_state_e state_q, state_d;

    logic [LANES-1:0]    pend_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES*DW-1:0] wdata_q;
    logic                wr_q;

    logic [LANES*BW-1:0] bank_of;
    logic [LANES*RW-1:0] row_of;

    logic [LANES-1:0] grant_b [BANKS];
    logic [BANKS-1:0] en_b;
    logic [RW-1:0]    row_b   [BANKS];
    logic [DW-1:0]    wd_b    [BANKS];

    logic [LANES-1:0] grant_all;
    logic [LANES-1:0] remaining;
    logic             accept;

    bcr_lane_map #(
        .LANES (LANES),
        .AW    (AW),
        .BW    (BW)
    ) u_map (
        .addr_flat (addr_q),
        .bank_flat (bank_of),
        .row_flat  (row_of)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bcr_bank_arb #(
            .LANES   (LANES),
            .BW      (BW),
            .RW      (RW),
            .DW      (DW),
            .BANK_ID (b)
        ) u_arb (
            .pend       (pend_q),
            .bank_flat  (bank_of),
            .row_flat   (row_of),
            .wdata_flat (wdata_q),
            .en         (en_b[b]),
            .row        (row_b[b]),
            .grant      (grant_b[b]),
            .wdata      (wd_b[b])
        );
    end

    always_comb begin
        grant_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            grant_all = grant_all | grant_b[b];
        end
    end

    assign remaining = pend_q & ~grant_all;
    assign accept    = req_valid && (|lane_active);
    assign lane_bank = bank_of;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SERVE;
            ST_SERVE: if (remaining == '0) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        pend_q  <= lane_active;
                        addr_q  <= lane_addr;
                        wdata_q <= lane_wdata;
                        wr_q    <= req_write;
                    end
                end
                ST_SERVE: pend_q <= remaining;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        lane_grant = '0;
        bank_en    = '0;
        bank_we    = '0;
        bank_addr  = '0;
        bank_wdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SERVE: begin
                busy       = 1'b1;
                lane_grant = grant_all;
                for (int b = 0; b < BANKS; b++) begin
                    bank_en[b]               = en_b[b];
                    bank_we[b]               = en_b[b] & wr_q;
                    bank_addr[b*RW +: RW]    = row_b[b];
                    bank_wdata[b*DW +: DW]   = wd_b[b];
                end
            end
        endcase
    end
endmodule

// File: rtl/bcr_chk.sv
module bcr_chk #(
    parameter int LANES = 32,
    parameter int BANKS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [LANES-1:0] lane_active,
    input logic             busy,
    input logic [LANES-1:0] lane_grant,
    input logic [BANKS-1:0] bank_en,
    input logic [BANKS-1:0] bank_we
);
    logic [LANES-1:0] act_q;
    logic [LANES-1:0] served_q;
    logic             wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            served_q <= '0;
            wr_q     <= 1'b0;
        end else if (busy) begin
            served_q <= served_q | lane_grant;
        end else if (req_valid && (|lane_active)) begin
            act_q    <= lane_active;
            served_q <= '0;
            wr_q     <= req_write;
        end
    end

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_grant == '0) && (bank_en == '0));

    // R7
    active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lane_grant & ~act_q) == '0);

    // R8
    grant_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_grant & served_q) == '0);

    // R8
    all_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> served_q == act_q);

    // R6
    progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lane_grant != '0);

    // R11
    read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_q) |-> bank_we == '0);

    // R10
    we_in_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we & ~bank_en) == '0);
endmodule

bind bank_conflict_resolver bcr_chk #(
    .LANES (LANES),
    .BANKS (BANKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .lane_active (lane_active),
    .busy        (busy),
    .lane_grant  (lane_grant),
    .bank_en     (bank_en),
    .bank_we     (bank_we)
);

// File: tb/bank_conflict_resolver_test.sv
module bank_conflict_resolver_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int BANKS = 32;
    localparam int AW    = 12;
    localparam int DW    = 32;
    localparam int BW    = 5;
    localparam int RW    = AW - BW;
    localparam int HMAX  = 64;

    typedef struct packed {
        logic [11:0] base;
        logic [11:0] stride;
        logic [31:0] act;
        logic [7:0]  cyc;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{12'd0, 12'd1,    32'hFFFF_FFFF, 8'd1},   // R3 unit stride
        '{12'd7, 12'd1,    32'hFFFF_FFFF, 8'd1},   // R3 unaligned base
        '{12'd0, 12'd33,   32'hFFFF_FFFF, 8'd1},   // R3 non-contiguous
        '{12'd5, 12'd0,    32'hFFFF_FFFF, 8'd1},   // R5 single word broadcast
        '{12'd0, 12'd2,    32'hFFFF_FFFF, 8'd2},   // R6 two-way conflict
        '{12'd0, 12'd16,   32'hFFFF_FFFF, 8'd16},  // R6 sixteen-way
        '{12'd0, 12'd32,   32'hFFFF_FFFF, 8'd32},  // R4 all lanes one bank
        '{12'd0, 12'd4,    32'h0000_FFFF, 8'd2},   // R7 half mask
        '{12'd3, 12'd32,   32'h0000_0005, 8'd2},   // R7 sparse mask
        '{12'd0, 12'd1024, 32'hFFFF_FFFF, 8'd4}    // R5 broadcast groups of 8
    };

    logic                clk;
    logic                rst_n;
    logic                req_valid;
    logic                req_write;
    logic [LANES-1:0]    lane_active;
    logic [LANES*AW-1:0] lane_addr;
    logic [LANES*DW-1:0] lane_wdata;
    logic                busy;
    logic [LANES-1:0]    lane_grant;
    logic [LANES*BW-1:0] lane_bank;
    logic [BANKS-1:0]    bank_en;
    logic [BANKS-1:0]    bank_we;
    logic [BANKS*RW-1:0] bank_addr;
    logic [BANKS*DW-1:0] bank_wdata;

    bank_conflict_resolver uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .lane_active (lane_active),
        .lane_addr   (lane_addr),
        .lane_wdata  (lane_wdata),
        .busy        (busy),
        .lane_grant  (lane_grant),
        .lane_bank   (lane_bank),
        .bank_en     (bank_en),
        .bank_we     (bank_we),
        .bank_addr   (bank_addr),
        .bank_wdata  (bank_wdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    logic [AW-1:0] ta [LANES];
    logic [DW-1:0] td [LANES];
    int            first_of [LANES];
    int            step [LANES];
    int            exp_cyc;

    logic [LANES-1:0]    g_hist  [HMAX];
    logic [BANKS-1:0]    en_hist [HMAX];
    logic [BANKS-1:0]    we_hist [HMAX];
    logic [BANKS*RW-1:0] ba_hist [HMAX];
    logic [BANKS*DW-1:0] wd_hist [HMAX];
    logic [LANES*BW-1:0] lb_snap;
    int                  n_seen;

    task automatic chk(input bit ok, input string tag, input string detail);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    // expected service step of each lane, from R4/R5
    task automatic model(input logic [LANES-1:0] act);
        exp_cyc = 0;
        for (int l = 0; l < LANES; l++) begin
            first_of[l] = -1;
            for (int j = 0; j <= l; j++) begin
                if (first_of[l] < 0 && act[j] && act[l] && ta[j] == ta[l]) first_of[l] = j;
            end
        end
        for (int l = 0; l < LANES; l++) begin
            step[l] = 0;
            if (act[l]) begin
                for (int j = 0; j < first_of[l]; j++) begin
                    if (act[j] && first_of[j] == j && ta[j][BW-1:0] == ta[l][BW-1:0]) step[l]++;
                end
                if (step[l] + 1 > exp_cyc) exp_cyc = step[l] + 1;
            end
        end
    endtask

    task automatic run_req(input logic wr, input logic [LANES-1:0] act, input bit poke);
        for (int l = 0; l < LANES; l++) begin
            lane_addr[l*AW +: AW]  = ta[l];
            lane_wdata[l*DW +: DW] = td[l];
        end
        req_write   = wr;
        lane_active = act;
        req_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_seen    = 0;
        lb_snap   = lane_bank;
        while (busy && n_seen < HMAX) begin
            g_hist[n_seen]  = lane_grant;
            en_hist[n_seen] = bank_en;
            we_hist[n_seen] = bank_we;
            ba_hist[n_seen] = bank_addr;
            wd_hist[n_seen] = bank_wdata;
            if (poke && n_seen == 0) begin
                req_valid   = 1'b1;
                lane_active = '1;
                lane_addr   = '0;
            end
            if (poke && n_seen == 1) req_valid = 1'b0;
            n_seen++;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    // grant sequence and bank addressing checks against the model
    task automatic check_sequence(input string tag, input logic [LANES-1:0] act);
        logic [LANES-1:0] exp_m;
        bit seq_ok = 1'b1;
        bit map_ok = 1'b1;
        string d_seq = "";
        string d_map = "";
        for (int c = 0; c < n_seen; c++) begin
            exp_m = '0;
            for (int l = 0; l < LANES; l++) if (act[l] && step[l] == c) exp_m[l] = 1'b1;
            if (seq_ok && g_hist[c] !== exp_m) begin
                seq_ok = 1'b0;
                d_seq = $sformatf("cycle %0d grant %h expected %h", c, g_hist[c], exp_m);
            end
            for (int l = 0; l < LANES; l++) begin
                if (g_hist[c][l] && map_ok) begin
                    if (!en_hist[c][ta[l][BW-1:0]] ||
                        ba_hist[c][ta[l][BW-1:0]*RW +: RW] !== ta[l][AW-1:BW] ||
                        lb_snap[l*BW +: BW] !== ta[l][BW-1:0]) begin
                        map_ok = 1'b0;
                        d_map = $sformatf("lane %0d bank %0d row %h expected bank %0d row %h",
                                          l, lb_snap[l*BW +: BW],
                                          ba_hist[c][ta[l][BW-1:0]*RW +: RW],
                                          ta[l][BW-1:0], ta[l][AW-1:BW]);
                    end
                end
            end
        end
        chk(seq_ok, {"R4/R5 ", tag}, d_seq);
        chk(map_ok, {"R2 ", tag}, d_map);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R8: busy=%0b expected run to end", busy);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        req_write   = 1'b0;
        lane_active = '0;
        lane_addr   = '0;
        lane_wdata  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && lane_grant == '0 && bank_en == '0 && bank_we == '0, "R1",
            $sformatf("busy=%0b grant=%h en=%h we=%h expected all zero",
                      busy, lane_grant, bank_en, bank_we));
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            for (int l = 0; l < LANES; l++) begin
                ta[l] = AW'(VECS[v].base + l * VECS[v].stride);
                td[l] = 32'hC000_0000 + l;
            end
            model(VECS[v].act);
            run_req(1'b0, VECS[v].act, 1'b0);
            chk(n_seen == int'(VECS[v].cyc) && n_seen == exp_cyc,
                $sformatf("R6 vec%0d", v),
                $sformatf("cycles %0d expected %0d", n_seen, VECS[v].cyc));
            check_sequence($sformatf("vec%0d", v), VECS[v].act);
            begin
                bit we_ok = 1'b1;
                for (int c = 0; c < n_seen; c++) if (we_hist[c] != '0) we_ok = 1'b0;
                chk(we_ok, $sformatf("R11 vec%0d", v), "bank_we nonzero on load, expected zero");
            end
            @(negedge clk);
        end

        // R7: request with no active lane is not accepted
        for (int l = 0; l < LANES; l++) ta[l] = AW'(l);
        run_req(1'b0, '0, 1'b0);
        chk(n_seen == 0 && busy == 1'b0 && lane_grant == '0, "R7",
            $sformatf("empty request busy cycles %0d expected 0", n_seen));

        // R10: store with several writers on one word; lane 1 on another row of bank 5
        for (int l = 0; l < LANES; l++) begin
            ta[l] = AW'(l);
            td[l] = 32'hA000 + l;
        end
        ta[1] = 12'd37;
        ta[3] = 12'd5;
        ta[7] = 12'd5;
        ta[9] = 12'd5;
        ta[5] = 12'd69;
        begin
            logic [LANES-1:0] act;
            act = (32'b1 << 1) | (32'b1 << 3) | (32'b1 << 7) | (32'b1 << 9);
            model(act);
            run_req(1'b1, act, 1'b0);
            chk(n_seen == 2, "R6 store", $sformatf("cycles %0d expected 2", n_seen));
            check_sequence("store", act);
            chk(we_hist[0] == (32'b1 << 5) && wd_hist[0][5*DW +: DW] == 32'hA001, "R10 store c0",
                $sformatf("we=%h data=%h expected we=%h data=A001",
                          we_hist[0], wd_hist[0][5*DW +: DW], 32'b1 << 5));
            chk(we_hist[1] == (32'b1 << 5) && wd_hist[1][5*DW +: DW] == 32'hA009 &&
                ba_hist[1][5*RW +: RW] == '0, "R10 store c1",
                $sformatf("we=%h data=%h row=%h expected data=A009 row=0",
                          we_hist[1], wd_hist[1][5*DW +: DW], ba_hist[1][5*RW +: RW]));
            @(negedge clk);

            // R11: same pattern as a load
            run_req(1'b0, act, 1'b0);
            chk(n_seen == 2 && we_hist[0] == '0 && we_hist[1] == '0, "R11 load",
                $sformatf("cycles %0d we0=%h we1=%h expected 2,0,0", n_seen, we_hist[0], we_hist[1]));
            @(negedge clk);
        end

        // R9: new request while busy is ignored
        for (int l = 0; l < LANES; l++) ta[l] = AW'(3 + 32 * l);
        model(32'h0000_0005);
        run_req(1'b0, 32'h0000_0005, 1'b1);
        chk(n_seen == 2, "R9 length", $sformatf("cycles %0d expected 2", n_seen));
        check_sequence("R9 poke", 32'h0000_0005);
        @(negedge clk);
        chk(busy == 1'b0 && lane_grant == '0, "R9 idle after",
            $sformatf("busy=%0b grant=%h expected 0", busy, lane_grant));

        // R1: reset in the middle of a request
        for (int l = 0; l < LANES; l++) ta[l] = AW'(32 * l);
        for (int l = 0; l < LANES; l++) lane_addr[l*AW +: AW] = ta[l];
        lane_active = '1;
        req_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && lane_grant == '0 && bank_en == '0, "R1 mid reset",
            $sformatf("busy=%0b grant=%h en=%h expected zero", busy, lane_grant, bank_en));
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule